// File: doc/BRIEF.md
# Debug Event Retirement Reporter

This block sits beside the retirement stage of a core and turns raw breakpoint and watchpoint matches into precise architectural events. Comparators in the fetch and load/store paths raise a match against the tag of an in-flight instruction. Each match carries a kind (instruction-side or load/store-side) and says whether it is a watchpoint (report only) or a breakpoint (exception). The block accumulates these per tag. It reports nothing until the tagged instruction retires. Matches on instructions that are recovered (flushed) are discarded.

On retirement the block pulses one watchpoint report per kind per retire slot. It advances one counter per kind by the number of distinct retiring instructions that carried that kind, and raises at most one breakpoint exception request per cycle. An instruction-side breakpoint requests the exception before execution, so the instruction does not complete. A load/store breakpoint requests it after execution, and only once every transfer of a multi-transfer access has finished. In that case the address of the matching access is captured for the handler. The block has no handshake and never stalls the pipeline: all outputs are registered one cycle behind the causing inputs.

Top module: `dbg_evt_retire`

## Requirements
- R1: A watchpoint report for retire slot s appears on `wp_ins_o[s]` (instruction kind, `match_kind_i`=0) or `wp_ls_o[s]` (load/store kind, `match_kind_i`=1) exactly one cycle after that slot retires an instruction that carried such a watchpoint match, and never otherwise.
- R2: Any number of matches of one kind on one instruction tag produce a single report and a single count for that kind when it retires.
- R3: Each counter advances in a cycle by the number of retiring slots reporting its kind (0, 1 or 2), is visible one cycle after retirement, and wraps at its width.
- R4: Two instructions retiring in the same cycle are both reported in that cycle; slot 0 (`ret_tag_i[TAG_W-1:0]`) is the oldest.
- R5: `flush_i` discards every pending match of instructions that are not retiring in that cycle; a later retirement of such a tag produces no report, count or exception.
- R6: An instruction-kind breakpoint (`match_brk_i`=1, kind 0) on a retiring instruction gives `brk_req_o`=1 with `brk_after_o`=0 one cycle later, and leaves `brk_addr_o` unchanged.
- R7: A load/store breakpoint on a retiring instruction whose transfers are complete (`ls_done_valid_i` seen for its tag, at the latest in the retire cycle) gives `brk_req_o`=1 with `brk_after_o`=1 one cycle later, and `brk_addr_o` shows the address of the first load/store breakpoint match of that instruction.
- R8: A load/store breakpoint that retires before its transfers complete is held; the request, with `brk_after_o`=1 and the held address, appears one cycle after `ls_done_valid_i` arrives for that tag.
- R9: When several retiring instructions carry breakpoints, only the oldest slot's is taken; within one instruction an instruction-kind breakpoint wins over a load/store one.
- R10: A held load/store breakpoint that completes takes the cycle's request, and retire-slot breakpoints of that cycle are dropped. A new deferral while one is held is dropped.
- R11: A match arriving in the same cycle as the retirement of its tag is included in that retirement.
- R12: After reset all reports, both counters, the request, the after flag and the address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_valid_i | input | 1 | A comparator match is presented |
| match_tag_i | input | TAG_W | Tag of the matching instruction |
| match_kind_i | input | 1 | 0 instruction-side, 1 load/store-side |
| match_brk_i | input | 1 | 1 breakpoint, 0 watchpoint |
| match_addr_i | input | ADDR_W | Access address of a load/store match |
| ls_done_valid_i | input | 1 | All transfers of an instruction have completed |
| ls_done_tag_i | input | TAG_W | Tag of that instruction |
| ret_valid_i | input | RET_W | Per-slot retirement valid, slot 0 oldest |
| ret_tag_i | input | RET_W*TAG_W | Per-slot retiring tags, slot s at bits s*TAG_W |
| flush_i | input | 1 | Recover: drop all non-retiring in-flight matches |
| wp_ins_o | output | RET_W | Per-slot instruction watchpoint report pulse |
| wp_ls_o | output | RET_W | Per-slot load/store watchpoint report pulse |
| cnt_ins_o | output | CNT_W | Instruction watchpoint event counter |
| cnt_ls_o | output | CNT_W | Load/store watchpoint event counter |
| brk_req_o | output | 1 | Breakpoint exception request pulse |
| brk_after_o | output | 1 | 1 after execution (load/store), 0 before |
| brk_addr_o | output | ADDR_W | Captured breakpoint access address |

## Verification
The bench aims at repeated matches on one tag and checks that they collapse to a single report and count. A design that counted transfers would overshoot the counter. It retires two watchpoint instructions together, where a counter that only increments would lose one. It flushes and then retires a stale tag to catch leaked reports. Several breakpoint orderings are covered: retire before transfer completion (an early request would show up), same-cycle matching and retirement, oldest-slot and instruction-over-load/store priority, and a held breakpoint that completes while another retires; a wrong winner shows up as a wrong after flag or address.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

  typedef enum logic {
    KIND_INS = 1'b0,
    KIND_LS  = 1'b1
  } evt_kind_e;

  typedef struct packed {
    logic wpi;
    logic wpl;
    logic bpi;
    logic bpl;
    logic done;
  } evt_flags_t;

  function automatic evt_flags_t merge_flags(evt_flags_t f, logic m_hit, logic kind,
                                             logic brk, logic d_hit);
    evt_flags_t r;
    r = f;
    if (m_hit) begin
      if (!brk && kind == KIND_INS) r.wpi = 1'b1;
      if (!brk && kind == KIND_LS)  r.wpl = 1'b1;
      if (brk && kind == KIND_INS)  r.bpi = 1'b1;
      if (brk && kind == KIND_LS)   r.bpl = 1'b1;
    end
    if (d_hit) r.done = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/dbg_evt_table.sv
module dbg_evt_table
  import dbg_evt_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 8,
  parameter int unsigned TAG_W    = $clog2(NUM_TAGS),
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned RET_W    = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    match_valid_i,
  input  logic [TAG_W-1:0]        match_tag_i,
  input  logic                    match_kind_i,
  input  logic                    match_brk_i,
  input  logic [ADDR_W-1:0]       match_addr_i,
  input  logic                    ls_done_valid_i,
  input  logic [TAG_W-1:0]        ls_done_tag_i,
  input  logic [RET_W-1:0]        ret_valid_i,
  input  logic [RET_W*TAG_W-1:0]  ret_tag_i,
  input  logic                    flush_i,
  output evt_flags_t [RET_W-1:0]  ret_flags_o,
  output logic [RET_W*ADDR_W-1:0] ret_addr_o
);

  evt_flags_t        flags [NUM_TAGS];
  logic [ADDR_W-1:0] addrs [NUM_TAGS];
  logic [NUM_TAGS-1:0] ret_hit;
  logic [NUM_TAGS-1:0] busy;

  always_comb begin
    ret_hit = '0;
    for (int s = 0; s < RET_W; s++) begin
      if (ret_valid_i[s]) ret_hit[ret_tag_i[s*TAG_W +: TAG_W]] = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_tag
    evt_flags_t        f_q;
    logic [ADDR_W-1:0] a_q;
    logic              m_hit, d_hit;

    assign m_hit = match_valid_i && (match_tag_i == TAG_W'(i));
    assign d_hit = ls_done_valid_i && (ls_done_tag_i == TAG_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= '0;
        a_q <= '0;
      end else begin
        if (flush_i || ret_hit[i]) f_q <= '0;
        else f_q <= merge_flags(f_q, m_hit, match_kind_i, match_brk_i, d_hit);
        // keep the address of the first load/store breakpoint access
        if (m_hit && match_brk_i && match_kind_i == KIND_LS && !f_q.bpl) a_q <= match_addr_i;
      end
    end

    assign flags[i] = f_q;
    assign addrs[i] = a_q;
    assign busy[i]  = f_q.wpi | f_q.wpl | f_q.bpi | f_q.bpl | f_q.done;
  end

  for (genvar s = 0; s < RET_W; s++) begin : g_slot
    logic [TAG_W-1:0] t;
    logic             m_hit, d_hit;
    assign t     = ret_tag_i[s*TAG_W +: TAG_W];
    assign m_hit = match_valid_i && (match_tag_i == t);
    assign d_hit = ls_done_valid_i && (ls_done_tag_i == t);
    assign ret_flags_o[s] = merge_flags(flags[t], m_hit, match_kind_i, match_brk_i, d_hit);
    assign ret_addr_o[s*ADDR_W +: ADDR_W] = flags[t].bpl ? addrs[t] : match_addr_i;
  end

  assert_flush_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy == '0));

endmodule

// File: rtl/dbg_evt_counter.sv
module dbg_evt_counter #(
  parameter int unsigned RET_W = 2,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RET_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, step;

  always_comb begin
    step = '0;
    for (int s = 0; s < RET_W; s++) step = step + CNT_W'(inc_i[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + step;
  end

  assign cnt_o = cnt_q;

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(RET_W));

endmodule

// File: rtl/dbg_brk_arb.sv
module dbg_brk_arb
  import dbg_evt_pkg::*;
#(
  parameter int unsigned RET_W  = 2,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [RET_W-1:0]        ret_valid_i,
  input  logic [RET_W*TAG_W-1:0]  ret_tag_i,
  input  evt_flags_t [RET_W-1:0]  ret_flags_i,
  input  logic [RET_W*ADDR_W-1:0] ret_addr_i,
  input  logic                    ls_done_valid_i,
  input  logic [TAG_W-1:0]        ls_done_tag_i,
  output logic                    brk_req_o,
  output logic                    brk_after_o,
  output logic [ADDR_W-1:0]       brk_addr_o
);

  localparam int unsigned SEL_W = (RET_W > 1) ? $clog2(RET_W) : 1;

  logic              pend_q, pend_n;
  logic [TAG_W-1:0]  ptag_q, ptag_n;
  logic [ADDR_W-1:0] paddr_q, paddr_n;
  logic              req_q, req_n, after_q, after_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              complete, found;
  logic [SEL_W-1:0]  sel;
  evt_flags_t        sf;

  assign complete = pend_q && ls_done_valid_i && (ls_done_tag_i == ptag_q);

  // oldest slot (lowest index) carrying a breakpoint
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int s = RET_W - 1; s >= 0; s--) begin
      if (ret_valid_i[s] && (ret_flags_i[s].bpi || ret_flags_i[s].bpl)) begin
        found = 1'b1;
        sel   = SEL_W'(s);
      end
    end
  end

  assign sf = ret_flags_i[sel];

  always_comb begin
    req_n   = 1'b0;
    after_n = 1'b0;
    addr_n  = addr_q;
    pend_n  = pend_q;
    ptag_n  = ptag_q;
    paddr_n = paddr_q;
    if (complete) begin
      req_n   = 1'b1;
      after_n = 1'b1;
      addr_n  = paddr_q;
      pend_n  = 1'b0;
    end else if (found) begin
      if (sf.bpi) begin
        req_n = 1'b1;
      end else if (sf.done) begin
        req_n   = 1'b1;
        after_n = 1'b1;
        addr_n  = ret_addr_i[int'(sel)*ADDR_W +: ADDR_W];
      end else if (!pend_q) begin
        pend_n  = 1'b1;
        ptag_n  = ret_tag_i[int'(sel)*TAG_W +: TAG_W];
        paddr_n = ret_addr_i[int'(sel)*ADDR_W +: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      ptag_q  <= '0;
      paddr_q <= '0;
      req_q   <= 1'b0;
      after_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      pend_q  <= pend_n;
      ptag_q  <= ptag_n;
      paddr_q <= paddr_n;
      req_q   <= req_n;
      after_q <= after_n;
      addr_q  <= addr_n;
    end
  end

  assign brk_req_o   = req_q;
  assign brk_after_o = after_q;
  assign brk_addr_o  = addr_q;

  assert_ins_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !after_q) |-> (addr_q == $past(addr_q)));

  assert_pend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !complete) |=> pend_q);

  assert_deferred_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete |=> (req_q && after_q && addr_q == $past(paddr_q)));

  assert_after_only_with_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    after_q |-> req_q);

endmodule

// File: rtl/dbg_evt_retire.sv
module dbg_evt_retire
  import dbg_evt_pkg::*;
#(
  parameter int unsigned NUM_TAGS = 8,
  parameter int unsigned TAG_W    = $clog2(NUM_TAGS),
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned RET_W    = 2,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   match_valid_i,
  input  logic [TAG_W-1:0]       match_tag_i,
  input  logic                   match_kind_i,
  input  logic                   match_brk_i,
  input  logic [ADDR_W-1:0]      match_addr_i,
  input  logic                   ls_done_valid_i,
  input  logic [TAG_W-1:0]       ls_done_tag_i,
  input  logic [RET_W-1:0]       ret_valid_i,
  input  logic [RET_W*TAG_W-1:0] ret_tag_i,
  input  logic                   flush_i,
  output logic [RET_W-1:0]       wp_ins_o,
  output logic [RET_W-1:0]       wp_ls_o,
  output logic [CNT_W-1:0]       cnt_ins_o,
  output logic [CNT_W-1:0]       cnt_ls_o,
  output logic                   brk_req_o,
  output logic                   brk_after_o,
  output logic [ADDR_W-1:0]      brk_addr_o
);

  evt_flags_t [RET_W-1:0]  ret_flags;
  logic [RET_W*ADDR_W-1:0] ret_addr;
  logic [RET_W-1:0]        hit_ins, hit_ls, wp_ins_q, wp_ls_q;

  dbg_evt_table #(
    .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .RET_W(RET_W)
  ) u_table (
    .clk_i, .rst_ni,
    .match_valid_i, .match_tag_i, .match_kind_i, .match_brk_i, .match_addr_i,
    .ls_done_valid_i, .ls_done_tag_i,
    .ret_valid_i, .ret_tag_i, .flush_i,
    .ret_flags_o(ret_flags),
    .ret_addr_o (ret_addr)
  );

  for (genvar s = 0; s < RET_W; s++) begin : g_rep
    assign hit_ins[s] = ret_valid_i[s] && ret_flags[s].wpi;
    assign hit_ls[s]  = ret_valid_i[s] && ret_flags[s].wpl;

    assert_report_on_retire_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wp_ins_q[s] || wp_ls_q[s]) |-> $past(ret_valid_i[s]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_ins_q <= '0;
      wp_ls_q  <= '0;
    end else begin
      wp_ins_q <= hit_ins;
      wp_ls_q  <= hit_ls;
    end
  end

  dbg_evt_counter #(.RET_W(RET_W), .CNT_W(CNT_W)) u_cnt_ins (
    .clk_i, .rst_ni, .inc_i(hit_ins), .cnt_o(cnt_ins_o)
  );

  dbg_evt_counter #(.RET_W(RET_W), .CNT_W(CNT_W)) u_cnt_ls (
    .clk_i, .rst_ni, .inc_i(hit_ls), .cnt_o(cnt_ls_o)
  );

  dbg_brk_arb #(.RET_W(RET_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_arb (
    .clk_i, .rst_ni,
    .ret_valid_i, .ret_tag_i,
    .ret_flags_i(ret_flags),
    .ret_addr_i (ret_addr),
    .ls_done_valid_i, .ls_done_tag_i,
    .brk_req_o, .brk_after_o, .brk_addr_o
  );

  assign wp_ins_o = wp_ins_q;
  assign wp_ls_o  = wp_ls_q;

endmodule

// File: tb/tb_dbg_evt_retire.sv
module tb_dbg_evt_retire;
  localparam int NT = 8;
  localparam int TW = 3;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic          match_valid, match_kind, match_brk;
  logic [TW-1:0] match_tag, ls_done_tag;
  logic [AW-1:0] match_addr;
  logic          ls_done_valid, flush;
  logic [1:0]    ret_valid;
  logic [2*TW-1:0] ret_tag;
  logic [1:0]    wp_ins, wp_ls;
  logic [CW-1:0] cnt_ins, cnt_ls;
  logic          brk_req, brk_after;
  logic [AW-1:0] brk_addr;

  dbg_evt_retire dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .match_valid_i(match_valid), .match_tag_i(match_tag), .match_kind_i(match_kind),
    .match_brk_i(match_brk), .match_addr_i(match_addr),
    .ls_done_valid_i(ls_done_valid), .ls_done_tag_i(ls_done_tag),
    .ret_valid_i(ret_valid), .ret_tag_i(ret_tag), .flush_i(flush),
    .wp_ins_o(wp_ins), .wp_ls_o(wp_ls), .cnt_ins_o(cnt_ins), .cnt_ls_o(cnt_ls),
    .brk_req_o(brk_req), .brk_after_o(brk_after), .brk_addr_o(brk_addr)
  );

  // reference state built from the requirements
  bit            m_wpi[NT], m_wpl[NT], m_bpi[NT], m_bpl[NT], m_done[NT];
  logic [AW-1:0] m_addr[NT];
  bit            m_pend;
  int            m_ptag;
  logic [AW-1:0] m_paddr;
  logic [1:0]    e_wpi, e_wpl;
  logic [CW-1:0] e_ci, e_cl;
  logic          e_req, e_after;
  logic [AW-1:0] e_addr;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    match_valid = 0; match_tag = '0; match_kind = 0; match_brk = 0; match_addr = '0;
    ls_done_valid = 0; ls_done_tag = '0; ret_valid = '0; ret_tag = '0; flush = 0;
  endtask

  task automatic set_match(int t, bit k, bit b, logic [AW-1:0] a);
    match_valid = 1; match_tag = TW'(t); match_kind = k; match_brk = b; match_addr = a;
  endtask

  task automatic set_ret(int s, int t);
    ret_valid[s] = 1'b1;
    ret_tag[s*TW +: TW] = TW'(t);
  endtask

  task automatic set_done(int t);
    ls_done_valid = 1; ls_done_tag = TW'(t);
  endtask

  task automatic model();
    bit fwi[2], fwl[2], fbi[2], fbl[2], fd[2], mh, rh, comp;
    logic [AW-1:0] fa[2];
    int t[2], sel;
    for (int s = 0; s < 2; s++) begin
      t[s] = int'(ret_tag[s*TW +: TW]);
      mh = match_valid && int'(match_tag) == t[s];
      fwi[s] = m_wpi[t[s]] | (mh && !match_brk && !match_kind);
      fwl[s] = m_wpl[t[s]] | (mh && !match_brk && match_kind);
      fbi[s] = m_bpi[t[s]] | (mh && match_brk && !match_kind);
      fbl[s] = m_bpl[t[s]] | (mh && match_brk && match_kind);
      fd[s]  = m_done[t[s]] | (ls_done_valid && int'(ls_done_tag) == t[s]);
      fa[s]  = m_bpl[t[s]] ? m_addr[t[s]] : match_addr;
      e_wpi[s] = ret_valid[s] && fwi[s];
      e_wpl[s] = ret_valid[s] && fwl[s];
    end
    e_ci = e_ci + CW'(e_wpi[0]) + CW'(e_wpi[1]);
    e_cl = e_cl + CW'(e_wpl[0]) + CW'(e_wpl[1]);
    e_req = 0; e_after = 0;
    comp = m_pend && ls_done_valid && int'(ls_done_tag) == m_ptag;
    if (comp) begin
      e_req = 1; e_after = 1; e_addr = m_paddr; m_pend = 0;
    end else begin
      sel = -1;
      for (int s = 1; s >= 0; s--) if (ret_valid[s] && (fbi[s] || fbl[s])) sel = s;
      if (sel >= 0) begin
        if (fbi[sel]) e_req = 1;
        else if (fd[sel]) begin e_req = 1; e_after = 1; e_addr = fa[sel]; end
        else if (!m_pend) begin m_pend = 1; m_ptag = t[sel]; m_paddr = fa[sel]; end
      end
    end
    for (int i = 0; i < NT; i++) begin
      rh = (ret_valid[0] && t[0] == i) || (ret_valid[1] && t[1] == i);
      mh = match_valid && int'(match_tag) == i;
      if (mh && match_brk && match_kind && !m_bpl[i]) m_addr[i] = match_addr;
      if (flush || rh) begin
        m_wpi[i] = 0; m_wpl[i] = 0; m_bpi[i] = 0; m_bpl[i] = 0; m_done[i] = 0;
      end else begin
        if (mh && !match_brk && !match_kind) m_wpi[i] = 1;
        if (mh && !match_brk && match_kind)  m_wpl[i] = 1;
        if (mh && match_brk && !match_kind)  m_bpi[i] = 1;
        if (mh && match_brk && match_kind)   m_bpl[i] = 1;
        if (ls_done_valid && int'(ls_done_tag) == i) m_done[i] = 1;
      end
    end
  endtask

  // apply current inputs for one edge, then compare at the falling edge
  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R1 wp_ins", 64'(wp_ins), 64'(e_wpi));
    chk("R1 wp_ls", 64'(wp_ls), 64'(e_wpl));
    chk("R3 cnt_ins", 64'(cnt_ins), 64'(e_ci));
    chk("R3 cnt_ls", 64'(cnt_ls), 64'(e_cl));
    chk("R9 brk_req/after", {62'd0, brk_req, brk_after}, {62'd0, e_req, e_after});
    chk("R7 brk_addr", 64'(brk_addr), 64'(e_addr));
    idle();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_ni = 0;
    e_ci = '0; e_cl = '0; e_req = 0; e_after = 0; e_addr = '0;
    m_pend = 0; m_ptag = 0; m_paddr = '0;
    for (int i = 0; i < NT; i++) begin
      m_wpi[i] = 0; m_wpl[i] = 0; m_bpi[i] = 0; m_bpl[i] = 0; m_done[i] = 0; m_addr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reports", {60'd0, wp_ins, wp_ls}, 64'd0);
    chk("R12 counters", {32'd0, cnt_ins, cnt_ls}, 64'd0);
    chk("R12 brk", {31'd0, brk_req, brk_after, brk_addr}, 64'd0);

    // R2: three load/store watch matches on one tag, one report
    for (int k = 0; k < 3; k++) begin set_match(2, 1, 0, AW'(k)); step(); end
    set_ret(0, 2); step();
    chk("R2 single ls report", 64'(wp_ls), 64'b01);
    chk("R2 single ls count", 64'(cnt_ls), 64'd1);

    // R4 / R3: two instructions retire together
    set_match(1, 0, 0, '0); step();
    set_match(6, 0, 0, '0); step();
    set_ret(0, 1); set_ret(1, 6); step();
    chk("R4 dual report", 64'(wp_ins), 64'b11);
    chk("R3 add two", 64'(cnt_ins), 64'd2);

    // R5: flushed match never reported
    set_match(5, 1, 0, '0); step();
    flush = 1; step();
    set_ret(0, 5); step();
    chk("R5 no report after flush", 64'(wp_ls), 64'd0);
    chk("R5 count unchanged", 64'(cnt_ls), 64'd1);

    // R6: instruction breakpoint fires before execution
    set_match(1, 0, 1, '0); step();
    set_ret(0, 1); step();
    chk("R6 req/after", {62'd0, brk_req, brk_after}, 64'b10);
    chk("R6 addr held", 64'(brk_addr), 64'd0);

    // R7: first load/store breakpoint address captured
    set_match(3, 1, 1, 32'hA000_0010); step();
    set_match(3, 1, 1, 32'hB000_0020); step();
    set_done(3); step();
    set_ret(0, 3); step();
    chk("R7 req/after", {62'd0, brk_req, brk_after}, 64'b11);
    chk("R7 first addr", 64'(brk_addr), 64'hA000_0010);

    // R8: retire before transfers complete
    set_match(4, 1, 1, 32'hC0DE_0004); step();
    set_ret(0, 4); step();
    chk("R8 held while incomplete", 64'(brk_req), 64'd0);
    set_done(4); step();
    chk("R8 req after done", {62'd0, brk_req, brk_after}, 64'b11);
    chk("R8 addr", 64'(brk_addr), 64'hC0DE_0004);

    // R9: oldest slot wins
    set_match(2, 1, 1, 32'hD000_0002); step();
    set_done(2); set_match(1, 0, 1, '0); step();
    set_ret(0, 2); set_ret(1, 1); step();
    chk("R9 oldest slot taken", {62'd0, brk_req, brk_after}, 64'b11);
    chk("R9 oldest addr", 64'(brk_addr), 64'hD000_0002);

    // R9: instruction kind wins within one instruction
    set_match(6, 1, 1, 32'h0000_0066); step();
    set_done(6); set_match(6, 0, 1, '0); step();
    set_ret(0, 6); step();
    chk("R9 ins over ls", {62'd0, brk_req, brk_after}, 64'b10);

    // R10: held breakpoint completes while another retires
    set_match(5, 1, 1, 32'hE000_0005); step();
    set_ret(0, 5); step();
    set_match(0, 0, 1, '0); step();
    set_done(5); set_ret(0, 0); step();
    chk("R10 deferred wins", {62'd0, brk_req, brk_after}, 64'b11);
    chk("R10 deferred addr", 64'(brk_addr), 64'hE000_0005);
    step();
    chk("R10 retire bp dropped", 64'(brk_req), 64'd0);

    // R11: match in the retire cycle
    set_match(7, 0, 0, '0); set_ret(0, 7); step();
    chk("R11 same-cycle match", 64'(wp_ins), 64'b01);
    chk("R11 count", 64'(cnt_ins), 64'd3);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int t0, t1;
      if ($urandom_range(9) < 6)
        set_match(int'($urandom_range(NT - 1)), 1'($urandom_range(1)),
                  ($urandom_range(3) == 0), AW'($urandom));
      if ($urandom_range(9) < 3) set_done(int'($urandom_range(NT - 1)));
      t0 = int'($urandom_range(NT - 1));
      t1 = (t0 + 1 + int'($urandom_range(NT - 2))) % NT;
      if ($urandom_range(1) == 1) set_ret(0, t0);
      if ($urandom_range(1) == 1) set_ret(1, t1);
      flush = ($urandom_range(19) == 0);
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule